// File: doc/BRIEF.md
# SONET Frame Aligner

This block sits behind a serial receive front end and turns a raw bit stream into aligned bytes. Bits arrive one per cycle in which `bit_en` is high. While hunting, the block compares a sliding window of the most recent bits with the framing pattern at every bit position. That pattern is a run of 0xF6 bytes followed by a run of 0x28 bytes. On the first match it fixes the byte boundary. From then on it delivers one byte per eight accepted bits on `byte_out`, qualified by `byte_vld`. It raises `frame_sync` on the byte that carries the first 0x28 of each frame found on that boundary.

The byte stream is delayed on purpose, so that the first 0x28 byte is on the bus in the same cycle that the whole window is confirmed. `rate_sel` picks the window size: three 0xF6 plus three 0x28 bytes for the lower rate, six of each for the four-times rate. A level on `oof` drops the alignment and restarts the hunt. Pulling `frm_en` low freezes the framer. The last boundary is kept and bytes keep flowing, but no hunt, no restart and no frame marker takes place.

Top module: `sonet_frame_aligner`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `byte_vld`, `frame_sync` and `byte_out` are all zero, and the block is not aligned.
- R2: With `rate_sel`=0, the pattern 0xF6,0xF6,0xF6,0x28,0x28,0x28 is found at any bit offset in the stream, and alignment is taken on the first match.
- R3: `frame_sync` is high for exactly one cycle. That cycle also has `byte_vld`=1 and `byte_out`=0x28, and it comes two clock cycles after the cycle in which the last bit of the window was presented with `bit_en` high.
- R4: The first serial bit of a byte appears on `byte_out[7]` and the last on `byte_out[0]`. After the marked byte, the bytes that follow it in the stream come out in order.
- R5: Once aligned, `byte_vld` pulses for one cycle after every eighth bit accepted with `bit_en`=1. Cycles with `bit_en`=0 add no bit to the stream.
- R6: With `rate_sel`=1, the window is six 0xF6 bytes followed by six 0x28 bytes. A three-plus-three pattern alone gives no alignment.
- R7: After alignment the boundary stays fixed. A pattern at another bit offset gives no `frame_sync`, while one on the held boundary gives it again.
- R8: With `frm_en`=1, `oof` high drops alignment from the next cycle on. No `byte_vld` or `frame_sync` appears while it stays high, and a new hunt starts once it falls.
- R9: With `frm_en`=0, no new alignment is taken and `oof` is ignored. An existing boundary keeps producing bytes, and `frame_sync` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Qualifies `bit_in` in this cycle |
| bit_in | input | 1 | Serial receive bit |
| rate_sel | input | 1 | 0: three-byte pattern runs, 1: six-byte pattern runs |
| oof | input | 1 | Out-of-frame level; restarts the hunt |
| frm_en | input | 1 | Framer enable; low holds the current boundary |
| byte_out | output | 8 | Aligned byte, first received bit in bit 7 |
| byte_vld | output | 1 | One-cycle strobe per aligned byte |
| frame_sync | output | 1 | Marks the first 0x28 byte of a frame |

## Verification
A bit presented in a cycle enters the window at the next edge. The byte or marker it completes is registered one edge after that, so every result is due two cycles after its last bit. The bench records the cycle in which it drives the final pattern bit, and it stamps each captured byte with the cycle it was sampled in, at the falling edge. It then compares the difference with two, and the spacing of strobes with eight cycles, or sixteen when `bit_en` idles every other cycle. Byte values and marker counts are checked against lists worked out from the sent stream and the two-byte or five-byte output delay.

// File: rtl/sfa_pkg.sv
`timescale 1ns/1ps
package sfa_pkg;
    localparam int          BYTE_BITS = 8;
    localparam logic [7:0]  A1_CODE   = 8'hF6;
    localparam logic [7:0]  A2_CODE   = 8'h28;

    typedef enum logic {
        RATE_LOW  = 1'b0,
        RATE_HIGH = 1'b1
    } sfa_rate_e;

    typedef struct packed {
        logic [BYTE_BITS-1:0] data;
        logic                 vld;
        logic                 sync;
    } sfa_beat_t;

    // Byte index b counts from the newest byte; the newest half holds A2.
    function automatic logic [7:0] pattern_byte(input int b, input int run);
        return (b < run) ? A2_CODE : A1_CODE;
    endfunction
endpackage

// File: rtl/sfa_shift_window.sv
`timescale 1ns/1ps
module sfa_shift_window #(
    parameter int WIN_BITS = 96
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bit_en,
    input  logic                bit_in,
    output logic [WIN_BITS-1:0] win,
    output logic                fresh
);
    always_ff @(posedge clk) begin
        if (rst) begin
            win   <= '0;
            fresh <= 1'b0;
        end else begin
            fresh <= bit_en;
            if (bit_en) begin
                win <= {win[WIN_BITS-2:0], bit_in};
            end
        end
    end
endmodule

// File: rtl/sfa_pattern_match.sv
`timescale 1ns/1ps
module sfa_pattern_match
    import sfa_pkg::*;
#(
    parameter int RUN_LO = 3,
    parameter int RUN_HI = 6,
    localparam int WIN_LO = 2 * RUN_LO * BYTE_BITS,
    localparam int WIN_HI = 2 * RUN_HI * BYTE_BITS
) (
    input  logic [WIN_HI-1:0]    win,
    input  sfa_rate_e            rate,
    output logic                 hit,
    output logic [BYTE_BITS-1:0] tap
);
    logic [WIN_LO-1:0] want_lo;
    logic [WIN_HI-1:0] want_hi;

    for (genvar b = 0; b < 2 * RUN_LO; b++) begin : g_lo
        assign want_lo[BYTE_BITS*b +: BYTE_BITS] = pattern_byte(b, RUN_LO);
    end
    for (genvar b = 0; b < 2 * RUN_HI; b++) begin : g_hi
        assign want_hi[BYTE_BITS*b +: BYTE_BITS] = pattern_byte(b, RUN_HI);
    end

    // The tap is the byte that holds the first A2 when the window matches.
    always_comb begin
        if (rate == RATE_HIGH) begin
            hit = (win == want_hi);
            tap = win[BYTE_BITS*RUN_HI-1 -: BYTE_BITS];
        end else begin
            hit = (win[WIN_LO-1:0] == want_lo);
            tap = win[BYTE_BITS*RUN_LO-1 -: BYTE_BITS];
        end
    end
endmodule

// File: rtl/sfa_align_ctrl.sv
`timescale 1ns/1ps
module sfa_align_ctrl
    import sfa_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 fresh,
    input  logic                 hit,
    input  logic [BYTE_BITS-1:0] tap,
    input  logic                 frm_en,
    input  logic                 oof,
    output sfa_beat_t            beat
);
    localparam int CNT_W = $clog2(BYTE_BITS);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_BITS - 1);

    logic             locked;
    logic [CNT_W-1:0] bit_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            locked  <= 1'b0;
            bit_cnt <= '0;
            beat    <= '0;
        end else begin
            beat.vld  <= 1'b0;
            beat.sync <= 1'b0;
            if (frm_en && oof) begin
                locked <= 1'b0;
            end else if (fresh) begin
                if (!locked) begin
                    if (frm_en && hit) begin
                        locked    <= 1'b1;
                        bit_cnt   <= '0;
                        beat.data <= tap;
                        beat.vld  <= 1'b1;
                        beat.sync <= 1'b1;
                    end
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                    if (bit_cnt == LAST_BIT) begin
                        beat.data <= tap;
                        beat.vld  <= 1'b1;
                        beat.sync <= hit && frm_en;
                    end
                end
            end
        end
    end

    AST_SYNC_IN_BEAT: assert property (@(posedge clk) disable iff (rst)
        beat.sync |-> beat.vld);                                   // R3
    AST_SYNC_FIRST_A2: assert property (@(posedge clk) disable iff (rst)
        beat.sync |-> (beat.data == A2_CODE));                     // R3
    AST_SYNC_SINGLE: assert property (@(posedge clk) disable iff (rst)
        beat.sync |=> !beat.sync);                                 // R3
    AST_BEAT_SPACED: assert property (@(posedge clk) disable iff (rst)
        beat.vld |=> !beat.vld);                                   // R5
    AST_BEAT_NEEDS_BIT: assert property (@(posedge clk) disable iff (rst)
        beat.vld |-> $past(fresh));                                // R5
    AST_OOF_DROPS: assert property (@(posedge clk) disable iff (rst)
        (oof && frm_en) |=> !beat.vld);                            // R8
    AST_HOLD_NO_SYNC: assert property (@(posedge clk) disable iff (rst)
        !frm_en |=> !beat.sync);                                   // R9
endmodule

// File: rtl/sonet_frame_aligner.sv
`timescale 1ns/1ps
module sonet_frame_aligner
    import sfa_pkg::*;
#(
    parameter int RUN_LO = 3,
    parameter int RUN_HI = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_en,
    input  logic       bit_in,
    input  logic       rate_sel,
    input  logic       oof,
    input  logic       frm_en,
    output logic [7:0] byte_out,
    output logic       byte_vld,
    output logic       frame_sync
);
    localparam int WIN_BITS = 2 * RUN_HI * BYTE_BITS;

    logic [WIN_BITS-1:0]  win;
    logic                 fresh;
    logic                 hit;
    logic [BYTE_BITS-1:0] tap;
    sfa_beat_t            beat;

    sfa_shift_window #(.WIN_BITS(WIN_BITS)) win_i (
        .clk    (clk),
        .rst    (rst),
        .bit_en (bit_en),
        .bit_in (bit_in),
        .win    (win),
        .fresh  (fresh)
    );

    sfa_pattern_match #(.RUN_LO(RUN_LO), .RUN_HI(RUN_HI)) match_i (
        .win  (win),
        .rate (sfa_rate_e'(rate_sel)),
        .hit  (hit),
        .tap  (tap)
    );

    sfa_align_ctrl ctrl_i (
        .clk    (clk),
        .rst    (rst),
        .fresh  (fresh),
        .hit    (hit),
        .tap    (tap),
        .frm_en (frm_en),
        .oof    (oof),
        .beat   (beat)
    );

    assign byte_out   = beat.data;
    assign byte_vld   = beat.vld;
    assign frame_sync = beat.sync;

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!byte_vld && !frame_sync && byte_out == 8'h00));  // R1
endmodule

// File: tb/sonet_frame_aligner_tb_top.sv
`timescale 1ns/1ps
module sonet_frame_aligner_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_en = 1'b0;
    logic       bit_in = 1'b0;
    logic       rate_sel = 1'b0;
    logic       oof = 1'b0;
    logic       frm_en = 1'b1;
    logic [7:0] byte_out;
    logic       byte_vld;
    logic       frame_sync;

    always #2.5 clk = ~clk;

    sonet_frame_aligner dut_i (
        .clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in),
        .rate_sel(rate_sel), .oof(oof), .frm_en(frm_en),
        .byte_out(byte_out), .byte_vld(byte_vld), .frame_sync(frame_sync)
    );

    int n_chk = 0, n_fail = 0, cyc = 0, mark = 0, last_cyc = 0;
    int cap_n = 0, sync_n = 0;
    logic [7:0] cap_d [64];
    logic       cap_s [64];
    int         cap_c [64];

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst && byte_vld) begin
            if (cap_n < 64) begin
                cap_d[cap_n] = byte_out;
                cap_s[cap_n] = frame_sync;
                cap_c[cap_n] = cyc;
            end
            cap_n++;
        end
        if (!rst && frame_sync) sync_n++;
    end

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic b, input logic en);
        @(posedge clk); #1;
        bit_in = b;
        bit_en = en;
    endtask

    task automatic idle(input int n);
        repeat (n) drive(1'b0, 1'b0);
    endtask

    task automatic send_bits(input int n, input logic [7:0] v);
        for (int i = n - 1; i >= 0; i--) drive(v[i], 1'b1);
        last_cyc = cyc;
    endtask

    task automatic send_byte(input logic [7:0] v);
        send_bits(8, v);
    endtask

    task automatic send_frame(input int na1, input int na2);
        repeat (na1) send_byte(8'hF6);
        repeat (na2) send_byte(8'h28);
        mark = last_cyc;
    endtask

    task automatic clear_cap();
        cap_n = 0;
        sync_n = 0;
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst = 1'b1; bit_en = 1'b0; bit_in = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    task automatic t_reset();
        @(posedge clk); #1 rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_eq("R1", "byte_vld in reset", int'(byte_vld), 0);
        check_eq("R1", "frame_sync in reset", int'(frame_sync), 0);
        check_eq("R1", "byte_out in reset", int'(byte_out), 0);
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk);
        check_eq("R1", "byte_vld after reset", int'(byte_vld), 0);
    endtask

    task automatic t_low_rate_lock();
        clear_cap();
        rate_sel = 1'b0;
        send_bits(3, 8'b101);
        send_byte(8'h00); send_byte(8'h13);
        send_frame(4, 3);
        send_byte(8'hA5); send_byte(8'h3C); send_byte(8'h0F); send_byte(8'h00);
        idle(3);
        check_eq("R5", "bytes after lock", cap_n, 5);
        check_eq("R2", "first byte", int'(cap_d[0]), 8'h28);
        check_eq("R3", "marker on first byte", int'(cap_s[0]), 1);
        check_eq("R3", "marker latency", cap_c[0] - mark, 2);
        check_eq("R3", "marker count", sync_n, 1);
        check_eq("R4", "fourth byte", int'(cap_d[3]), 8'hA5);
        check_eq("R4", "fifth byte", int'(cap_d[4]), 8'h3C);
        check_eq("R5", "strobe spacing", cap_c[1] - cap_c[0], 8);
    endtask

    task automatic t_gaps();
        logic [7:0] v;
        clear_cap();
        v = 8'h5A;
        for (int i = 7; i >= 0; i--) begin drive(v[i], 1'b1); drive(1'b1, 1'b0); end
        v = 8'h66;
        for (int i = 7; i >= 0; i--) begin drive(v[i], 1'b1); drive(1'b1, 1'b0); end
        idle(3);
        check_eq("R5", "bytes with gaps", cap_n, 2);
        check_eq("R5", "gap byte 0", int'(cap_d[0]), 8'h0F);
        check_eq("R5", "gap byte 1", int'(cap_d[1]), 8'h00);
        check_eq("R5", "gap spacing", cap_c[1] - cap_c[0], 16);
    endtask

    task automatic t_misalign();
        clear_cap();
        send_bits(5, 8'b01101);
        send_frame(3, 3);
        repeat (3) send_byte(8'h00);
        idle(3);
        check_eq("R7", "marker off boundary", sync_n, 0);
        check_eq("R7", "bytes keep flowing", cap_n, 9);
        clear_cap();
        send_bits(3, 8'b000);
        send_frame(3, 3);
        repeat (3) send_byte(8'h00);
        idle(3);
        check_eq("R7", "marker on boundary count", sync_n, 1);
        check_eq("R7", "marker position", int'(cap_s[6]), 1);
        check_eq("R7", "marker byte", int'(cap_d[6]), 8'h28);
        check_eq("R7", "marker latency", cap_c[6] - mark, 2);
    endtask

    task automatic t_oof();
        clear_cap();
        oof = 1'b1;
        send_frame(3, 3);
        repeat (3) send_byte(8'h00);
        idle(2);
        check_eq("R8", "bytes while oof", cap_n, 0);
        check_eq("R8", "markers while oof", sync_n, 0);
        oof = 1'b0;
        clear_cap();
        send_bits(2, 8'b10);
        send_frame(3, 3);
        repeat (3) send_byte(8'h00);
        idle(3);
        check_eq("R8", "relock bytes", cap_n, 4);
        check_eq("R8", "relock marker", int'(cap_s[0]), 1);
        check_eq("R8", "relock byte", int'(cap_d[0]), 8'h28);
        check_eq("R8", "relock latency", cap_c[0] - mark, 2);
    endtask

    task automatic t_hold();
        clear_cap();
        frm_en = 1'b0;
        oof = 1'b1;
        send_frame(3, 3);
        repeat (3) send_byte(8'h00);
        idle(3);
        check_eq("R9", "held bytes", cap_n, 9);
        check_eq("R9", "no marker when held", sync_n, 0);
        oof = 1'b0;
        do_reset();
        clear_cap();
        send_bits(2, 8'b01);
        send_frame(3, 3);
        repeat (3) send_byte(8'h00);
        idle(3);
        check_eq("R9", "no lock when disabled", cap_n, 0);
        frm_en = 1'b1;
    endtask

    task automatic t_high_rate();
        do_reset();
        rate_sel = 1'b1;
        clear_cap();
        send_bits(3, 8'b101);
        send_frame(3, 3);
        repeat (3) send_byte(8'h00);
        idle(3);
        check_eq("R6", "short pattern ignored", cap_n, 0);
        clear_cap();
        send_frame(6, 6);
        repeat (3) send_byte(8'h00);
        idle(3);
        check_eq("R6", "bytes after lock", cap_n, 4);
        check_eq("R6", "first byte", int'(cap_d[0]), 8'h28);
        check_eq("R6", "marker", int'(cap_s[0]), 1);
        check_eq("R6", "marker latency", cap_c[0] - mark, 2);
        check_eq("R6", "marker count", sync_n, 1);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    bit done = 1'b0;

    initial begin
        repeat (4) @(posedge clk);
        t_reset();
        t_low_rate_lock();
        t_gaps();
        t_misalign();
        t_oof();
        t_hold();
        t_high_rate();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule